// File: doc/BRIEF.md
# Multicart Banked Memory Mapper

This block sits between a console's two buses and a cartridge that holds several game images in one large program ROM and one large pattern ROM. The CPU programs it through a write port. Inside the upper half of the CPU space, eight register slots are decoded. The block then turns every CPU program-window address and every PPU pattern address into an extended ROM address. It also drives the nametable mirroring select.

Each game image sees an ordinary set of switchable banks. These are two 8 KB program banks with two fixed ones, plus two 2 KB and four 1 KB pattern banks. An outer game-select register, written at one exact address below the program space, offsets the whole program map in steps of eight banks and the pattern map in steps of 128 banks. A strap input selects an alternate decoding of that outer register. In that mode the fixed program banks also move lower inside each outer slice.

All register updates happen on a rising clock edge while the write strobe is high. The translated addresses are combinational from the current register state.

Top module: `multicart_mapper`

## Requirements
- R1: After reset the program windows 0x8000/0xA000/0xC000/0xE000 map to 8 KB banks 0, 1, 14, 15; pattern 1 KB slots 0x0000..0x1C00 map to banks 0..7; mirroring output is 0 (vertical).
- R2: Writes with address bit 15 set are decoded by address AND 0xE001, so an aliased address such as 0x9FFE acts as 0x8000 and 0x9FFF acts as 0x8001.
- R3: A write to slot 0x8000 stores the control byte; a write to slot 0x8001 loads the bank register indexed by control bits 2..0 (0,1: 2 KB pattern pairs with data bit 0 forced to 0; 2..5: 1 KB pattern; 6,7: 8 KB program).
- R4: With control bit 6 clear, program windows 0x8000/0xA000/0xC000/0xE000 use register 6, register 7, fixed low bank, fixed high bank; program ROM address is {bank, cpu_addr[12:0]}.
- R5: With control bit 6 set, the 0x8000 and 0xC000 windows swap: fixed low bank, register 7, register 6, fixed high bank.
- R6: With control bit 7 clear, pattern 0x0000-0x07FF uses pair register 0 (banks n, n+1), 0x0800-0x0FFF pair register 1, and 0x1000/0x1400/0x1800/0x1C00 use registers 2..5; pattern ROM address is {bank, ppu_addr[9:0]}.
- R7: With control bit 7 set, the two 4 KB pattern halves swap: registers 2..5 cover 0x0000-0x0FFF and the pairs cover 0x1000-0x1FFF.
- R8: Only a write to exactly 0x6000 loads the outer value; in normal strap mode it becomes {data bit 0, 0}; other addresses below 0x8000 change nothing.
- R9: In alternate strap mode a write to 0x6000 loads data bits 2..1 as the outer value, and while the outer value is not 2 the fixed program banks are 6 and 7 instead of 14 and 15.
- R10: The final program bank is outer value times 8 plus the selected bank, without wrap (9-bit bank number).
- R11: The final pattern bank adds 128 to the selected bank when outer value bit 1 is set.
- R12: A write to slot 0xA000 sets the mirroring output to data bit 0 (1 = horizontal, 0 = vertical).
- R13: Writes to slots 0xA001, 0xC000, 0xC001, 0xE000 and 0xE001 change no mapping and no mirroring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_waddr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| alt_outer | input | 1 | Strap: alternate outer-register decoding |
| cpu_addr | input | 16 | CPU program fetch address (0x8000-0xFFFF) |
| ppu_addr | input | 13 | PPU pattern address |
| prg_rom_addr | output | 22 | Extended program ROM address |
| chr_rom_addr | output | 19 | Extended pattern ROM address |
| mirror_horiz | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
The bench targets the forced-even pair registers. A design that kept bit 0 would map 0x0000 to an odd bank. It checks both swap bits in each state, because a design that swapped the wrong windows would return register 6 where a fixed bank belongs. The alternate strap is tried with outer values 1, 2 and 3, since only value 2 keeps the fixed banks at 14 and 15. A design that compared against the wrong value would report 6 or 30 in the wrong case. Aliased addresses, near-miss outer addresses (0x6001, 0x7000) and the interrupt slots are written as well. A decoder that used too few address bits would corrupt the mapping there.

// File: rtl/mapper_pkg.sv
// Shared definitions for the multicart mapper.
// Assumes a byte-wide CPU data bus and the 0xE001 slot decode.
package mapper_pkg;

    // Register slot, formed as {addr[14:13], addr[0]} for addr[15] = 1
    typedef enum logic [2:0] {
        SLOT_SEL    = 3'd0,   // 0x8000
        SLOT_DATA   = 3'd1,   // 0x8001
        SLOT_MIRROR = 3'd2,   // 0xA000
        SLOT_A001   = 3'd3,
        SLOT_C000   = 3'd4,
        SLOT_C001   = 3'd5,
        SLOT_E000   = 3'd6,
        SLOT_E001   = 3'd7
    } slot_e;

    // Reset content of bank register idx: pattern 0,2,4,5,6,7 then program 0,1
    function automatic logic [7:0] bank_reset_val(input int idx);
        if (idx < 2)      return 8'(idx * 2);
        else if (idx < 6) return 8'(idx + 2);
        else              return 8'(idx - 6);
    endfunction

endpackage

// File: rtl/mapper_regs.sv
// Register file of the mapper: control byte, eight bank registers, outer
// game-select value and mirroring bit. Decodes CPU writes. Assumes the
// write strobe is a one-cycle qualifier sampled on the rising edge.
module mapper_regs
    import mapper_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int NUM_REGS  = 8,
    parameter int OUTER_W   = 2,
    parameter logic [AW-1:0] OUTER_ADDR = 16'h6000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [AW-1:0]                waddr,
    input  logic [DW-1:0]                wdata,
    input  logic                         alt_outer,
    output logic [DW-1:0]                ctrl_o,
    output logic [NUM_REGS-1:0][DW-1:0]  bank_o,
    output logic [OUTER_W-1:0]           outer_o,
    output logic                         mirror_o
);
    localparam int SEL_W = $clog2(NUM_REGS);

    slot_e               slot;
    logic                hi_wr;
    logic                outer_wr;
    logic [DW-1:0]       ctrl_q;
    logic [OUTER_W-1:0]  outer_q;
    logic [OUTER_W-1:0]  outer_nxt;
    logic                mirror_q;
    logic [SEL_W-1:0]    sel;

    // Purpose: decode the write into a slot and detect the outer-register hit
    always_comb begin
        slot     = slot_e'({waddr[AW-2:AW-3], waddr[0]});
        hi_wr    = wr && waddr[AW-1];
        outer_wr = wr && (waddr == OUTER_ADDR);
        sel      = ctrl_q[SEL_W-1:0];
    end

    // Purpose: pick the outer value according to the strap decoding
    always_comb begin
        if (alt_outer) outer_nxt = wdata[OUTER_W:1];
        else           outer_nxt = {wdata[0], {(OUTER_W-1){1'b0}}};
    end

    // Purpose: control byte register
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (hi_wr && slot == SLOT_SEL)  ctrl_q <= wdata;
    end

    // Purpose: mirroring bit register
    always_ff @(posedge clk) begin
        if (!rst_n)                             mirror_q <= 1'b0;
        else if (hi_wr && slot == SLOT_MIRROR)  mirror_q <= wdata[0];
    end

    // Purpose: outer game-select register
    always_ff @(posedge clk) begin
        if (!rst_n)        outer_q <= '0;
        else if (outer_wr) outer_q <= outer_nxt;
    end

    // Purpose: one bank register per index; pair registers keep bit 0 clear
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic [DW-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q <= bank_reset_val(g);
            else if (hi_wr && slot == SLOT_DATA && sel == SEL_W'(g)) begin
                if (g < 2) bank_q <= {wdata[DW-1:1], 1'b0};
                else       bank_q <= wdata;
            end
        end
        assign bank_o[g] = bank_q;
    end

    assign ctrl_o   = ctrl_q;
    assign outer_o  = outer_q;
    assign mirror_o = mirror_q;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && waddr[AW-1] && waddr[AW-2:AW-3] == 2'b00 && !waddr[0]) |=> $stable(ctrl_o)); // R2
    AST_OUTER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waddr == OUTER_ADDR && !alt_outer) |=> !outer_o[0]); // R8
    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waddr[AW-1] && waddr[AW-2:AW-3] == 2'b01 && !waddr[0]) |=> mirror_o == $past(wdata[0])); // R12

endmodule

// File: rtl/prg_xlate.sv
// Program address translation: picks the 8 KB bank for the CPU window
// given by address bits 14..13, adds the outer offset, and forms the ROM
// address. Assumes only 0x8000-0xFFFF fetches are routed here.
module prg_xlate #(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int OUTER_W   = 2,
    parameter int OFF_W     = 13,
    parameter int OUTER_SHIFT = 3,
    parameter int FIX_NORMAL  = 14,
    parameter int FIX_ALT     = 6,
    parameter int OUTER_KEEP  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  swap,
    input  logic                  alt_outer,
    input  logic [OUTER_W-1:0]    outer,
    input  logic [DW-1:0]         reg_a,
    input  logic [DW-1:0]         reg_b,
    input  logic [AW-1:0]         cpu_addr,
    output logic [DW+OFF_W:0]     rom_addr
);
    localparam int BANK_W = DW + 1;

    logic [1:0]        win;
    logic [DW-1:0]     fix_lo;
    logic [DW-1:0]     fix_hi;
    logic [DW-1:0]     sel_bank;
    logic [BANK_W-1:0] bank;

    // Purpose: choose the fixed bank pair for the current strap and outer value
    always_comb begin
        if (alt_outer && outer != OUTER_W'(OUTER_KEEP)) fix_lo = DW'(FIX_ALT);
        else                                            fix_lo = DW'(FIX_NORMAL);
        fix_hi = fix_lo + DW'(1);
    end

    // Purpose: select the window's bank, honouring the swap bit
    always_comb begin
        win = cpu_addr[OFF_W+1:OFF_W];
        unique case (win)
            2'd0:    sel_bank = swap ? fix_lo : reg_a;
            2'd1:    sel_bank = reg_b;
            2'd2:    sel_bank = swap ? reg_a : fix_lo;
            default: sel_bank = fix_hi;
        endcase
    end

    // Purpose: add the outer offset and append the window offset
    always_comb begin
        bank     = (BANK_W'(outer) << OUTER_SHIFT) + BANK_W'(sel_bank);
        rom_addr = {bank, cpu_addr[OFF_W-1:0]};
    end

    AST_LAST_WIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[OFF_W+1:OFF_W] == 2'd3) |-> rom_addr[OFF_W+2:OFF_W] == 3'b111); // R4
    AST_SECOND_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[OFF_W+1:OFF_W] == 2'd1) |-> rom_addr[OFF_W+2:OFF_W] == reg_b[2:0]); // R5

endmodule

// File: rtl/chr_xlate.sv
// Pattern address translation: picks the 1 KB bank for a PPU pattern
// address from two pair registers and four single registers, with the
// 4 KB half swap, then adds the outer pattern offset.
module chr_xlate #(
    parameter int DW        = 8,
    parameter int OUTER_W   = 2,
    parameter int OFF_W     = 10,
    parameter int OUTER_SHIFT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 swap,
    input  logic [OUTER_W-1:0]   outer,
    input  logic [5:0][DW-1:0]   regs,
    input  logic [OFF_W+2:0]     ppu_addr,
    output logic [DW+OFF_W:0]    rom_addr
);
    localparam int BANK_W = DW + 1;

    logic              pair_half;
    logic [DW-1:0]     sel_bank;
    logic [BANK_W-1:0] bank;

    // Purpose: select the pair or single register for the addressed slot
    always_comb begin
        pair_half = (ppu_addr[OFF_W+2] == swap);
        if (pair_half)
            sel_bank = (ppu_addr[OFF_W+1] ? regs[1] : regs[0]) + DW'(ppu_addr[OFF_W]);
        else
            sel_bank = regs[2 + 32'(ppu_addr[OFF_W+1:OFF_W])];
    end

    // Purpose: add the outer pattern offset and append the slot offset
    always_comb begin
        bank     = (BANK_W'(outer[OUTER_W-1]) << OUTER_SHIFT) + BANK_W'(sel_bank);
        rom_addr = {bank, ppu_addr[OFF_W-1:0]};
    end

    AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[OFF_W+2] == swap) |-> rom_addr[OFF_W] == ppu_addr[OFF_W]); // R3

endmodule

// File: rtl/multicart_mapper.sv
// Top of the multicart mapper: register file plus program and pattern
// translators. Assumes CPU writes are presented with a single-cycle strobe.
module multicart_mapper #(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int NUM_REGS = 8,
    parameter int OUTER_W  = 2,
    parameter int PRG_OFF_W = 13,
    parameter int CHR_OFF_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_wr,
    input  logic [AW-1:0]               cpu_waddr,
    input  logic [DW-1:0]               cpu_wdata,
    input  logic                        alt_outer,
    input  logic [AW-1:0]               cpu_addr,
    input  logic [CHR_OFF_W+2:0]        ppu_addr,
    output logic [DW+PRG_OFF_W:0]       prg_rom_addr,
    output logic [DW+CHR_OFF_W:0]       chr_rom_addr,
    output logic                        mirror_horiz
);
    localparam int PRG_SWAP_BIT = 6;
    localparam int CHR_SWAP_BIT = 7;

    logic [DW-1:0]               ctrl;
    logic [NUM_REGS-1:0][DW-1:0] banks;
    logic [OUTER_W-1:0]          outer;
    logic [5:0][DW-1:0]          chr_regs;

    mapper_regs #(
        .AW(AW), .DW(DW), .NUM_REGS(NUM_REGS), .OUTER_W(OUTER_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .waddr(cpu_waddr),
        .wdata(cpu_wdata), .alt_outer(alt_outer), .ctrl_o(ctrl),
        .bank_o(banks), .outer_o(outer), .mirror_o(mirror_horiz)
    );

    prg_xlate #(
        .AW(AW), .DW(DW), .OUTER_W(OUTER_W), .OFF_W(PRG_OFF_W)
    ) u_prg (
        .clk(clk), .rst_n(rst_n), .swap(ctrl[PRG_SWAP_BIT]),
        .alt_outer(alt_outer), .outer(outer), .reg_a(banks[6]),
        .reg_b(banks[7]), .cpu_addr(cpu_addr), .rom_addr(prg_rom_addr)
    );

    // Purpose: hand the six pattern registers to the pattern translator
    always_comb begin
        for (int i = 0; i < 6; i++) chr_regs[i] = banks[i];
    end

    chr_xlate #(
        .DW(DW), .OUTER_W(OUTER_W), .OFF_W(CHR_OFF_W)
    ) u_chr (
        .clk(clk), .rst_n(rst_n), .swap(ctrl[CHR_SWAP_BIT]),
        .outer(outer), .regs(chr_regs), .ppu_addr(ppu_addr),
        .rom_addr(chr_rom_addr)
    );

endmodule

// File: tb/multicart_mapper_tb.sv
module multicart_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_waddr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        alt_outer = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic [12:0] ppu_addr = '0;
    logic [21:0] prg_rom_addr;
    logic [18:0] chr_rom_addr;
    logic        mirror_horiz;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multicart_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .alt_outer(alt_outer), .cpu_addr(cpu_addr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
    );

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_waddr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic chk_prg(input logic [15:0] a, input int bank, input string req);
        logic [21:0] exp;
        cpu_addr = a;
        #1;
        exp = {9'(bank), a[12:0]};
        checks++;
        if (prg_rom_addr !== exp) begin
            errors++;
            $display("FAIL %s prg addr %h: actual %h expected %h", req, a, prg_rom_addr, exp);
        end
    endtask

    task automatic chk_chr(input logic [12:0] a, input int bank, input string req);
        logic [18:0] exp;
        ppu_addr = a;
        #1;
        exp = {9'(bank), a[9:0]};
        checks++;
        if (chr_rom_addr !== exp) begin
            errors++;
            $display("FAIL %s chr addr %h: actual %h expected %h", req, a, chr_rom_addr, exp);
        end
    endtask

    task automatic chk_mir(input logic exp, input string req);
        #1;
        checks++;
        if (mirror_horiz !== exp) begin
            errors++;
            $display("FAIL %s mirror: actual %b expected %b", req, mirror_horiz, exp);
        end
    endtask

    task automatic t_reset;   // R1
        chk_prg(16'h8123, 0, "R1");
        chk_prg(16'hA456, 1, "R1");
        chk_prg(16'hC001, 14, "R1");
        chk_prg(16'hFFFF, 15, "R1");
        for (int i = 0; i < 8; i++) chk_chr(13'(i * 1024 + 5), i, "R1");
        chk_mir(1'b0, "R1");
    endtask

    task automatic t_bank_load;   // R3 R4 R6
        wr(16'h8000, 8'h06); wr(16'h8001, 8'h21);
        wr(16'h8000, 8'h07); wr(16'h8001, 8'h30);
        chk_prg(16'h8010, 8'h21, "R4");
        chk_prg(16'hA010, 8'h30, "R4");
        chk_prg(16'hC010, 14, "R4");
        wr(16'h8000, 8'h00); wr(16'h8001, 8'h13);
        wr(16'h8000, 8'h01); wr(16'h8001, 8'h45);
        for (int i = 0; i < 4; i++) begin
            wr(16'h8000, 8'(2 + i)); wr(16'h8001, 8'(8'h50 + i));
        end
        chk_chr(13'h0000, 8'h12, "R3");
        chk_chr(13'h0400, 8'h13, "R3");
        chk_chr(13'h0800, 8'h44, "R3");
        chk_chr(13'h0C00, 8'h45, "R3");
        chk_chr(13'h1000, 8'h50, "R6");
        chk_chr(13'h1400, 8'h51, "R6");
        chk_chr(13'h1800, 8'h52, "R6");
        chk_chr(13'h1FFF, 8'h53, "R6");
    endtask

    task automatic t_alias;   // R2
        wr(16'h9FFE, 8'h07);
        wr(16'h9FFF, 8'h3A);
        chk_prg(16'hA000, 8'h3A, "R2");
        chk_prg(16'h8000, 8'h21, "R2");
    endtask

    task automatic t_prg_swap;   // R5
        wr(16'h8000, 8'h46);
        chk_prg(16'h8000, 14, "R5");
        chk_prg(16'hA000, 8'h3A, "R5");
        chk_prg(16'hC000, 8'h21, "R5");
        chk_prg(16'hE000, 15, "R5");
    endtask

    task automatic t_chr_swap;   // R7
        wr(16'h8000, 8'h80);
        chk_chr(13'h0000, 8'h50, "R7");
        chk_chr(13'h0C00, 8'h53, "R7");
        chk_chr(13'h1000, 8'h12, "R7");
        chk_chr(13'h1400, 8'h13, "R7");
        chk_chr(13'h1800, 8'h44, "R7");
        chk_chr(13'h1C00, 8'h45, "R7");
        chk_prg(16'h8000, 8'h21, "R4");
        chk_prg(16'hC000, 14, "R4");
    endtask

    task automatic t_mirror;   // R12
        wr(16'hA000, 8'h01); chk_mir(1'b1, "R12");
        wr(16'hA000, 8'hFE); chk_mir(1'b0, "R12");
        wr(16'hBFFE, 8'h01); chk_mir(1'b1, "R12");
    endtask

    task automatic t_ignored;   // R13 R8
        wr(16'hA001, 8'hFE);
        wr(16'hC000, 8'hFF);
        wr(16'hC001, 8'hFF);
        wr(16'hE000, 8'hFF);
        wr(16'hE001, 8'hFF);
        wr(16'h6001, 8'h01);
        wr(16'h7000, 8'h01);
        chk_prg(16'h8000, 8'h21, "R13");
        chk_prg(16'hC000, 14, "R8");
        chk_chr(13'h0000, 8'h50, "R13");
        chk_chr(13'h1000, 8'h12, "R13");
        chk_mir(1'b1, "R13");
    endtask

    task automatic t_outer_normal;   // R8 R10 R11
        wr(16'h6000, 8'h01);
        chk_prg(16'h8000, 16 + 8'h21, "R10");
        chk_prg(16'hC000, 30, "R10");
        chk_prg(16'hE000, 31, "R10");
        chk_chr(13'h0000, 128 + 8'h50, "R11");
        chk_chr(13'h1400, 128 + 8'h13, "R11");
        wr(16'h6000, 8'hFE);
        chk_prg(16'h8000, 8'h21, "R8");
        chk_chr(13'h0000, 8'h50, "R8");
    endtask

    task automatic t_outer_alt;   // R9
        alt_outer = 1'b1;
        wr(16'h6000, 8'h02);
        chk_prg(16'h8000, 8 + 8'h21, "R9");
        chk_prg(16'hC000, 8 + 6, "R9");
        chk_prg(16'hE000, 8 + 7, "R9");
        chk_chr(13'h0000, 8'h50, "R9");
        wr(16'h6000, 8'h04);
        chk_prg(16'hC000, 30, "R9");
        chk_prg(16'hE000, 31, "R9");
        chk_chr(13'h0000, 128 + 8'h50, "R9");
        wr(16'h6000, 8'h06);
        chk_prg(16'h8000, 24 + 8'h21, "R9");
        chk_prg(16'hC000, 30, "R9");
        chk_chr(13'h0000, 128 + 8'h50, "R9");
        wr(16'h6000, 8'h01);
        chk_prg(16'hC000, 6, "R9");
        chk_prg(16'hE000, 7, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_load();
        t_alias();
        t_prg_swap();
        t_chr_swap();
        t_mirror();
        t_ignored();
        t_outer_normal();
        t_outer_alt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule